// File: doc/BRIEF.md
# Two-Level Standby Controller

This block sits beside the CPU of a small microcontroller and manages two depths of standby. A shallow standby (HALT) gates only the CPU clock and leaves every oscillator and peripheral running. A deep standby (STOP) also turns off the main oscillator. In STOP each peripheral keeps a run permission only if its count clock comes from a source that survives: an external pin or the subsystem clock.

Firmware enters standby by pulsing one of two request strobes. The controller checks that the request is legal. Deep standby is refused while the CPU runs from the subsystem clock, and any request made while already in standby is refused. A refused request produces a one-cycle error pulse. Any enabled interrupt request or enabled test request wakes the block. A wake from HALT restores the CPU clock on the next cycle. A wake from STOP first turns the oscillator back on and keeps the CPU gated for a programmable settling time.

Top module: `standby_ctrl`

## Requirements
- R1: The mode output encodes RUN=0, HALT=1, STOP=2, SETTLE=3. In RUN, `main_osc_en`, `cpu_clk_en` and every peripheral enable are 1.
- R2: In RUN, `stop_req` with `clk_sel_sub`=0 moves the block to STOP at the next clock edge. When `stop_req` and `halt_req` are both present and STOP is legal, STOP wins.
- R3: In RUN, `halt_req` moves the block to HALT at the next clock edge whichever value `clk_sel_sub` has, unless a legal STOP is requested in the same cycle.
- R4: In STOP the outputs are as follows:
  - `main_osc_en`=0, `cpu_clk_en`=0, `en_bt`=0 and `en_adc`=0.
  - `en_sio` equals `sio_ext_clk`, `en_tmr` equals `tmr_ext_src` and `en_wt` equals `wt_sub_src`.
  - `ext_int_en[3:1]` are all 1, and `ext_int_en[0]` equals `int0_filter_bypass`.
- R5: In HALT and SETTLE, `cpu_clk_en`=0, while `main_osc_en` and every peripheral enable are 1.
- R6: Wake is true when any bit of `irq_req & irq_en` or of `tst_req & tst_en` is 1. Wake in HALT returns the block to RUN at the next edge. Wake in RUN has no effect.
- R7: Wake in STOP moves the block to SETTLE and samples `settle_cycles` (N) at that edge. The block stays in SETTLE for exactly N+1 cycles and then enters RUN. Changes to `settle_cycles` during SETTLE are ignored.
- R8: `rst_n` low at a clock edge forces RUN, with the oscillator enabled, `entry_err`=0 and any settling count discarded.
- R9: In the cycle after an ignored request, `entry_err` is 1 for exactly one cycle, and the mode is unchanged by that request. A request is ignored when it is a STOP request while `clk_sel_sub`=1, or any request in HALT, STOP or SETTLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stop_req | input | 1 | Deep-standby entry strobe |
| halt_req | input | 1 | Shallow-standby entry strobe |
| clk_sel_sub | input | 1 | 1 when the CPU runs from the subsystem clock |
| irq_req | input | N_IRQ | Interrupt requests |
| irq_en | input | N_IRQ | Interrupt enable flags |
| tst_req | input | N_TEST | Test requests |
| tst_en | input | N_TEST | Test enable flags |
| settle_cycles | input | SETTLE_W | Oscillator settling length minus one |
| sio_ext_clk | input | 1 | Serial interface clocked from its external pin |
| tmr_ext_src | input | 1 | Timer/event counter clocked from pin or subsystem watch tick |
| wt_sub_src | input | 1 | Watch timer counts the subsystem clock |
| int0_filter_bypass | input | 1 | Noise filter of external interrupt 0 bypassed |
| main_osc_en | output | 1 | Main oscillator enable |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| en_bt | output | 1 | Interval/watchdog timer run enable |
| en_sio | output | 1 | Serial interface run enable |
| en_tmr | output | 1 | Timer/event counter run enable |
| en_wt | output | 1 | Watch timer run enable |
| en_adc | output | 1 | A/D converter run enable |
| ext_int_en | output | 4 | External interrupt input enables, bit 0 is interrupt 0 |
| mode | output | 2 | Current mode code |
| entry_err | output | 1 | One-cycle pulse after an ignored request |

## Verification
The bench goes after the following corner cases:
- A STOP request while the subsystem clock is selected. A design that skipped this check would shut the oscillator the CPU depends on.
- STOP and HALT requested together. A design with the wrong priority would land in the shallow mode.
- A settling length of zero, and `settle_cycles` changing mid-count. An off-by-one or a live read of `settle_cycles` would open the CPU clock early or late.
- Requests arriving during standby or during settling. A design that honoured them would move to a different mode, and one that failed to flag them would miss the error pulse.
- Reset arriving mid-settle. A design that kept the stale count would keep the CPU gated after reset.

// File: rtl/stby_pkg.sv
// Shared types for the standby controller.
// Assumes a 2-bit mode code that is visible at the top-level port.
package stby_pkg;
    typedef enum logic [1:0] {
        MODE_RUN    = 2'd0,
        MODE_HALT   = 2'd1,
        MODE_STOP   = 2'd2,
        MODE_SETTLE = 2'd3
    } stby_mode_e;

    localparam int unsigned EXT_INT_N = 4;
endpackage

// File: rtl/stby_wake.sv
// Wake detector: ORs together every enabled interrupt request and every
// enabled test request. Assumes the request inputs are already synchronous
// to clk.
module stby_wake #(
    parameter int unsigned N_IRQ  = 8,
    parameter int unsigned N_TEST = 2
) (
    input  logic [N_IRQ-1:0]  irq_req,
    input  logic [N_IRQ-1:0]  irq_en,
    input  logic [N_TEST-1:0] tst_req,
    input  logic [N_TEST-1:0] tst_en,
    output logic              wake
);
    logic [N_IRQ-1:0]  irq_hit;
    logic [N_TEST-1:0] tst_hit;

    // Mask each source with its own enable flag.
    genvar gi;
    generate
        for (gi = 0; gi < N_IRQ; gi++) begin : g_irq
            assign irq_hit[gi] = irq_req[gi] & irq_en[gi];
        end
        for (gi = 0; gi < N_TEST; gi++) begin : g_tst
            assign tst_hit[gi] = tst_req[gi] & tst_en[gi];
        end
    endgenerate

    // A single enabled source is enough to wake.
    always_comb wake = (|irq_hit) | (|tst_hit);
endmodule

// File: rtl/stby_fsm.sv
// Mode state machine with entry legality checks and the oscillator settling
// counter. Assumes request strobes are single-cycle. Reset is synchronous
// and active low.
module stby_fsm
    import stby_pkg::*;
#(
    parameter int unsigned SETTLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                stop_req,
    input  logic                halt_req,
    input  logic                clk_sel_sub,
    input  logic                wake,
    input  logic [SETTLE_W-1:0] settle_cycles,
    output stby_mode_e          mode_q,
    output logic                err_q
);
    stby_mode_e          mode_d;
    logic [SETTLE_W-1:0] cnt_q, cnt_d;
    logic                err_d;
    logic                stop_ok;

    // STOP is legal only from RUN on the main clock.
    always_comb stop_ok = stop_req && !clk_sel_sub;

    // Next-state, counter and error decode.
    always_comb begin
        mode_d = mode_q;
        cnt_d  = cnt_q;
        err_d  = 1'b0;
        unique case (mode_q)
            MODE_RUN: begin
                err_d = stop_req && clk_sel_sub;
                if (stop_ok)       mode_d = MODE_STOP;
                else if (halt_req) mode_d = MODE_HALT;
            end
            MODE_HALT: begin
                err_d = stop_req || halt_req;
                if (wake) mode_d = MODE_RUN;
            end
            MODE_STOP: begin
                err_d = stop_req || halt_req;
                if (wake) begin
                    mode_d = MODE_SETTLE;
                    cnt_d  = settle_cycles;
                end
            end
            MODE_SETTLE: begin
                err_d = stop_req || halt_req;
                if (cnt_q == '0) mode_d = MODE_RUN;
                else             cnt_d  = cnt_q - 1'b1;
            end
            default: mode_d = MODE_RUN;
        endcase
    end

    // State registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_RUN;
            cnt_q  <= '0;
            err_q  <= 1'b0;
        end else begin
            mode_q <= mode_d;
            cnt_q  <= cnt_d;
            err_q  <= err_d;
        end
    end
endmodule

// File: rtl/stby_gate.sv
// Peripheral permission decode. Each peripheral may run while the main
// oscillator runs, or while its own clock source survives the oscillator
// being off. Assumes the clock-source selects are quasi-static.
module stby_gate
    import stby_pkg::*;
(
    input  stby_mode_e             mode,
    input  logic                   sio_ext_clk,
    input  logic                   tmr_ext_src,
    input  logic                   wt_sub_src,
    input  logic                   int0_filter_bypass,
    output logic                   main_osc_en,
    output logic                   cpu_clk_en,
    output logic                   en_bt,
    output logic                   en_sio,
    output logic                   en_tmr,
    output logic                   en_wt,
    output logic                   en_adc,
    output logic [EXT_INT_N-1:0]   ext_int_en
);
    // The oscillator is off only in deep standby; the CPU runs only in RUN.
    always_comb begin
        main_osc_en = (mode != MODE_STOP);
        cpu_clk_en  = (mode == MODE_RUN);
    end

    // Peripheral run permissions follow the oscillator or a surviving source.
    always_comb begin
        en_bt      = main_osc_en;
        en_adc     = main_osc_en;
        en_sio     = main_osc_en | sio_ext_clk;
        en_tmr     = main_osc_en | tmr_ext_src;
        en_wt      = main_osc_en | wt_sub_src;
        ext_int_en = {{(EXT_INT_N-1){1'b1}}, main_osc_en | int0_filter_bypass};
    end
endmodule

// File: rtl/standby_ctrl.sv
// Top level of the two-level standby controller: wake detection, mode FSM
// and peripheral permission decode. Assumes every input is synchronous to clk.
module standby_ctrl #(
    parameter int unsigned N_IRQ    = 8,
    parameter int unsigned N_TEST   = 2,
    parameter int unsigned SETTLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                stop_req,
    input  logic                halt_req,
    input  logic                clk_sel_sub,
    input  logic [N_IRQ-1:0]    irq_req,
    input  logic [N_IRQ-1:0]    irq_en,
    input  logic [N_TEST-1:0]   tst_req,
    input  logic [N_TEST-1:0]   tst_en,
    input  logic [SETTLE_W-1:0] settle_cycles,
    input  logic                sio_ext_clk,
    input  logic                tmr_ext_src,
    input  logic                wt_sub_src,
    input  logic                int0_filter_bypass,
    output logic                main_osc_en,
    output logic                cpu_clk_en,
    output logic                en_bt,
    output logic                en_sio,
    output logic                en_tmr,
    output logic                en_wt,
    output logic                en_adc,
    output logic [3:0]          ext_int_en,
    output logic [1:0]          mode,
    output logic                entry_err
);
    import stby_pkg::*;

    logic       wake;
    stby_mode_e mode_q;

    stby_wake #(.N_IRQ(N_IRQ), .N_TEST(N_TEST)) u_wake (
        .irq_req (irq_req),
        .irq_en  (irq_en),
        .tst_req (tst_req),
        .tst_en  (tst_en),
        .wake    (wake)
    );

    stby_fsm #(.SETTLE_W(SETTLE_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .stop_req      (stop_req),
        .halt_req      (halt_req),
        .clk_sel_sub   (clk_sel_sub),
        .wake          (wake),
        .settle_cycles (settle_cycles),
        .mode_q        (mode_q),
        .err_q         (entry_err)
    );

    stby_gate u_gate (
        .mode               (mode_q),
        .sio_ext_clk        (sio_ext_clk),
        .tmr_ext_src        (tmr_ext_src),
        .wt_sub_src         (wt_sub_src),
        .int0_filter_bypass (int0_filter_bypass),
        .main_osc_en        (main_osc_en),
        .cpu_clk_en         (cpu_clk_en),
        .en_bt              (en_bt),
        .en_sio             (en_sio),
        .en_tmr             (en_tmr),
        .en_wt              (en_wt),
        .en_adc             (en_adc),
        .ext_int_en         (ext_int_en)
    );

    // Export the mode code.
    always_comb mode = mode_q;
endmodule

// File: rtl/stby_chk.sv
// Property checker for standby_ctrl, attached through bind. It only
// observes ports and does not drive anything.
module stby_chk #(
    parameter int unsigned N_IRQ  = 8,
    parameter int unsigned N_TEST = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stop_req,
    input logic              halt_req,
    input logic              clk_sel_sub,
    input logic [N_IRQ-1:0]  irq_req,
    input logic [N_IRQ-1:0]  irq_en,
    input logic [N_TEST-1:0] tst_req,
    input logic [N_TEST-1:0] tst_en,
    input logic              main_osc_en,
    input logic              cpu_clk_en,
    input logic [1:0]        mode,
    input logic              entry_err
);
    logic wake_in;
    always_comb wake_in = (|(irq_req & irq_en)) | (|(tst_req & tst_en));

    a_r2_stop_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0 && stop_req && !clk_sel_sub) |=> (mode == 2'd2));

    a_r9_stop_on_sub_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0 && stop_req && clk_sel_sub) |=> (mode != 2'd2 && entry_err));

    a_r4_stop_osc_off: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2) |-> (!main_osc_en && !cpu_clk_en));

    a_r5_shallow_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd1 || mode == 2'd3) |-> (main_osc_en && !cpu_clk_en));

    a_r6_halt_release: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd1 && wake_in) |=> (mode == 2'd0));

    a_r7_stop_to_settle: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2 && wake_in) |=> (mode == 2'd3));

    a_r8_reset_run: assert property (@(posedge clk)
        !rst_n |=> (mode == 2'd0 && main_osc_en && !entry_err));

    a_r1_run_clocks: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0) |-> (cpu_clk_en && main_osc_en));
endmodule

bind standby_ctrl stby_chk #(.N_IRQ(N_IRQ), .N_TEST(N_TEST)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .stop_req    (stop_req),
    .halt_req    (halt_req),
    .clk_sel_sub (clk_sel_sub),
    .irq_req     (irq_req),
    .irq_en      (irq_en),
    .tst_req     (tst_req),
    .tst_en      (tst_en),
    .main_osc_en (main_osc_en),
    .cpu_clk_en  (cpu_clk_en),
    .mode        (mode),
    .entry_err   (entry_err)
);

// File: tb/sim_standby_ctrl.sv
module sim_standby_ctrl;
    localparam int NI = 8;
    localparam int NT = 2;
    localparam int SW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stop_req = 0, halt_req = 0, clk_sel_sub = 0;
    logic [NI-1:0] irq_req = '0, irq_en = '0;
    logic [NT-1:0] tst_req = '0, tst_en = '0;
    logic [SW-1:0] settle_cycles = '0;
    logic sio_ext_clk = 0, tmr_ext_src = 0, wt_sub_src = 0, int0_filter_bypass = 0;
    logic main_osc_en, cpu_clk_en, en_bt, en_sio, en_tmr, en_wt, en_adc, entry_err;
    logic [3:0] ext_int_en;
    logic [1:0] mode;

    int checks = 0, fails = 0;

    // Reference model state
    logic [1:0]    m_mode = 2'd0;
    logic [SW-1:0] m_cnt  = '0;
    logic          m_err  = 1'b0;

    always #4 clk = ~clk;

    standby_ctrl #(.N_IRQ(NI), .N_TEST(NT), .SETTLE_W(SW)) u0 (
        .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .halt_req(halt_req),
        .clk_sel_sub(clk_sel_sub), .irq_req(irq_req), .irq_en(irq_en),
        .tst_req(tst_req), .tst_en(tst_en), .settle_cycles(settle_cycles),
        .sio_ext_clk(sio_ext_clk), .tmr_ext_src(tmr_ext_src), .wt_sub_src(wt_sub_src),
        .int0_filter_bypass(int0_filter_bypass), .main_osc_en(main_osc_en),
        .cpu_clk_en(cpu_clk_en), .en_bt(en_bt), .en_sio(en_sio), .en_tmr(en_tmr),
        .en_wt(en_wt), .en_adc(en_adc), .ext_int_en(ext_int_en), .mode(mode),
        .entry_err(entry_err));

    // Expected output vector {osc,cpu,bt,sio,tmr,wt,adc,int[3:0]} per R1/R4/R5
    function automatic logic [10:0] exp_outs(input logic [1:0] md);
        logic osc;
        osc = (md != 2'd2);
        return {osc, md == 2'd0, osc, osc | sio_ext_clk, osc | tmr_ext_src,
                osc | wt_sub_src, osc, 3'b111, osc | int0_filter_bypass};
    endfunction

    // Advance the reference model by one clock edge.
    function automatic void model_step();
        logic wk;
        wk = (|(irq_req & irq_en)) | (|(tst_req & tst_en));
        if (!rst_n) begin
            m_mode = 2'd0; m_cnt = '0; m_err = 1'b0;
            return;
        end
        m_err = (m_mode == 2'd0) ? (stop_req && clk_sel_sub) : (stop_req || halt_req);
        case (m_mode)
            2'd0: if (stop_req && !clk_sel_sub) m_mode = 2'd2;
                  else if (halt_req) m_mode = 2'd1;
            2'd1: if (wk) m_mode = 2'd0;
            2'd2: if (wk) begin m_mode = 2'd3; m_cnt = settle_cycles; end
            default: if (m_cnt == '0) m_mode = 2'd0; else m_cnt = m_cnt - 1'b1;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, expv, $time);
        end
    endtask

    // Compare all outputs against the model; tag names the requirement.
    task automatic check_all(input string tag);
        chk({tag, " mode"}, 32'(mode), 32'(m_mode));
        chk({tag, " outs R1 R4 R5"},
            32'({main_osc_en, cpu_clk_en, en_bt, en_sio, en_tmr, en_wt, en_adc, ext_int_en}),
            32'(exp_outs(m_mode)));
        chk({tag, " entry_err R9"}, 32'(entry_err), 32'(m_err));
    endtask

    // One cycle: inputs already driven, clock edge, model update, check at negedge.
    task automatic cycle(input string tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
        check_all(tag);
    endtask

    task automatic clear_in();
        stop_req = 0; halt_req = 0; irq_req = '0; tst_req = '0;
    endtask

    initial begin : watchdog
        #1000000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240601));
        @(negedge clk);
        cycle("R8 reset");
        rst_n = 1;
        irq_en = 8'h01; tst_en = 2'b01;

        // R2 legal STOP, with HALT at the same time: STOP wins
        stop_req = 1; halt_req = 1; cycle("R2 stop priority");
        clear_in(); cycle("R4 in stop");
        sio_ext_clk = 1; int0_filter_bypass = 1; cycle("R4 stop sources");
        sio_ext_clk = 0; int0_filter_bypass = 0; wt_sub_src = 1; tmr_ext_src = 1;
        halt_req = 1; cycle("R9 req in stop");
        clear_in(); wt_sub_src = 0; tmr_ext_src = 0;
        irq_req = 8'h02; cycle("R6 disabled irq no wake");
        // R7 wake with settle 0: one SETTLE cycle
        settle_cycles = 0; irq_req = 8'h01; cycle("R7 wake");
        clear_in(); cycle("R7 settle end");
        // R9 STOP on subsystem clock
        clk_sel_sub = 1; stop_req = 1; cycle("R9 stop on sub");
        clear_in(); cycle("R9 pulse ends");
        // R3 HALT on sub clock, then R6 test release
        halt_req = 1; cycle("R3 halt sub");
        clear_in(); tst_req = 2'b01; cycle("R6 test wake");
        clear_in(); clk_sel_sub = 0; irq_req = 8'h01; cycle("R6 wake in run");
        // R7 settle 3, settle input changed mid-count, then R8 reset mid-settle
        clear_in(); stop_req = 1; cycle("R2 stop");
        clear_in(); settle_cycles = 3; tst_req = 2'b01; cycle("R7 wake load");
        clear_in(); settle_cycles = 0;
        for (int i = 0; i < 4; i++) cycle("R7 settle count");
        stop_req = 1; cycle("R2 stop again");
        clear_in(); settle_cycles = 9; irq_req = 8'h01; cycle("R7 load 9");
        clear_in(); cycle("R7 counting"); halt_req = 1; cycle("R9 req in settle");
        clear_in(); rst_n = 0; cycle("R8 reset mid settle");
        rst_n = 1; cycle("R8 after reset");

        // Random phase
        for (int i = 0; i < 3000; i++) begin
            stop_req = ($urandom_range(0, 9) == 0);
            halt_req = ($urandom_range(0, 9) == 0);
            clk_sel_sub = ($urandom_range(0, 3) == 0);
            irq_req = ($urandom_range(0, 5) == 0) ? 8'($urandom) : '0;
            irq_en  = 8'($urandom);
            tst_req = ($urandom_range(0, 9) == 0) ? 2'($urandom) : '0;
            tst_en  = 2'($urandom);
            settle_cycles = 8'($urandom_range(0, 6));
            sio_ext_clk = 1'($urandom); tmr_ext_src = 1'($urandom);
            wt_sub_src = 1'($urandom); int0_filter_bypass = 1'($urandom);
            rst_n = ($urandom_range(0, 199) != 0);
            cycle("R1-random R6 R7 R9");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule